// File: doc/BRIEF.md
# Paged PLL Clock-Control Register

This block is one byte-wide control/status register for a PLL clock subsystem, reached at one address on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Bit 7 of the register is a page selector. With the page bit at 0 the address reaches a plain 8-bit storage view. With the page bit at 1 it reaches the clock-control view. That view holds the VCO free-run mode, the PLL enable and the clock-source select, and it reports a lock flag that only hardware drives.

Software writes to the control view pass through interlocks. The PLL cannot be switched off while it clocks the system. The PLL clock cannot be chosen while the PLL is off. Two inputs override software. An option-byte input forces the PLL clock as the source. A programming-session input forces the VCO mode, the PLL enable and the source select on while it is held. The block drives the control levels for an external clock multiplexer and clock detector. The PLL lock time is modelled by a cycle counter.

Top module: `pll_clkctl_reg`

## Requirements
- R1: After reset the register reads 00h. The page bit, the storage view and every control bit are 0, and all control outputs are low.
- R2: Every write to the register address loads the page bit from write data bit 7. A write while the page bit is 0 loads write data bits 6..0 into the storage view, which reads back as {page bit, stored bits 6..0}. A write while the page bit is 1 leaves the storage view unchanged.
- R3: With the page bit at 1, a read returns bit 7 = 1, bit 6 = VCO mode, bit 5 = lock, bit 4 = PLL enable and bit 1 = clock-source select. Bits 3, 2 and 0 read 0.
- R4: The lock bit ignores software. It reads 1 once PLL enable has been 1 for LOCK_CYCLES clock edges without a break. It reads 0 in the same cycle that PLL enable is 0.
- R5: A write with bit 4 = 0 to the control view does not clear PLL enable while clock-source select is 1. Such a write still applies its other bits.
- R6: A write with bit 1 = 1 to the control view does not set clock-source select if PLL enable is 0 after that same write. A single write that sets both bit 4 and bit 1 is accepted. Clock-source select = 1 always implies PLL enable = 1.
- R7: While the option input is high, clock-source select and PLL enable are held at 1, whatever is written.
- R8: While the programming-session input is high, VCO mode, PLL enable and clock-source select are held at 1. After it falls, software may clear clock-source select and then PLL enable.
- R9: The outputs follow the register bits. The PLL enable output and the clock-detector enable output both equal PLL enable. The source-select output equals clock-source select, the VCO-mode output equals VCO mode, and the lock output equals the lock bit.
- R10: A write to any other address changes nothing, and a read of any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the addressed view |
| opt_pll_src | input | 1 | Option override that forces the PLL clock as the source |
| prog_session | input | 1 | Programming-session force |
| vco_mode_o | output | 1 | VCO free-run mode level |
| pll_en_o | output | 1 | PLL enable level |
| ckd_en_o | output | 1 | Clock-detector enable level |
| clk_src_pll_o | output | 1 | Clock multiplexer select: 1 selects the PLL clock |
| lock_o | output | 1 | PLL lock flag |

## Verification
The bench drives writes that try to clear PLL enable and source select together while the PLL clock is selected. A design that checked the new select value instead of the current one would let the PLL drop while it clocks the system. It drives a single write that sets PLL enable and source select at once, which a design filtering against the old PLL enable would reject. It also writes 1 to the lock bit and counts lock-in edges exactly, so an off-by-one counter or a lock that lingers one cycle after PLL enable falls shows up as a miscompare. Option and session forces are held across writes that try to undo them. The bench also checks that control-view writes leave the storage view alone.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int PAGE_BIT  = 7;
  localparam int VCO_BIT   = 6;
  localparam int LOCK_BIT  = 5;
  localparam int PLLEN_BIT = 4;
  localparam int SEL_BIT   = 1;

  typedef struct packed {
    logic vco;
    logic pll_en;
    logic sel;
  } ctl_bits_t;

  // Read image of the control view; unlisted bits stay 0.
  function automatic logic [7:0] pack_ctl_view(input ctl_bits_t c, input logic lock);
    logic [7:0] img;
    img            = 8'h00;
    img[PAGE_BIT]  = 1'b1;
    img[VCO_BIT]   = c.vco;
    img[LOCK_BIT]  = lock;
    img[PLLEN_BIT] = c.pll_en;
    img[SEL_BIT]   = c.sel;
    return img;
  endfunction
endpackage

// File: rtl/clkctl_lock_timer.sv
module clkctl_lock_timer #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_en,
  output logic locked_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!pll_en)       cnt_q <= '0;
    else if (!cnt_full)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_full = (cnt_q == CNT_FULL);
  assign locked_o = pll_en & cnt_full;

  // R4: lock never shown while the PLL is off
  p_lock_needs_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !locked_o);
  // R4: lock cannot already be set on the cycle the PLL turns on
  p_lock_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !locked_o);
endmodule

// File: rtl/clkctl_interlock.sv
module clkctl_interlock
  import clkctl_pkg::*;
(
  input  logic      wr_ctl,
  input  logic      want_vco,
  input  logic      want_pll,
  input  logic      want_sel,
  input  ctl_bits_t cur,
  input  logic      opt_force,
  input  logic      prog_force,
  output ctl_bits_t nxt,
  output logic      pll_clr_blocked,
  output logic      sel_set_blocked
);
  logic pll_after_wr;
  logic sel_after_wr;
  logic vco_after_wr;

  always_comb begin
    // PLL enable may only fall if the PLL clock is not currently selected.
    pll_after_wr = wr_ctl ? (want_pll | cur.sel) : cur.pll_en;
    // Source select is judged against the PLL enable this same write produces.
    sel_after_wr = wr_ctl ? (want_sel & pll_after_wr) : cur.sel;
    vco_after_wr = wr_ctl ? want_vco : cur.vco;

    nxt.pll_en = pll_after_wr | opt_force | prog_force;
    nxt.sel    = sel_after_wr | opt_force | prog_force;
    nxt.vco    = vco_after_wr | prog_force;
  end

  assign pll_clr_blocked = wr_ctl & ~want_pll & cur.sel;
  assign sel_set_blocked = wr_ctl & want_sel & ~pll_after_wr;
endmodule

// File: rtl/pll_clkctl_reg.sv
module pll_clkctl_reg
  import clkctl_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 4'h9,
  parameter int              LOCK_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              opt_pll_src,
  input  logic              prog_session,
  output logic              vco_mode_o,
  output logic              pll_en_o,
  output logic              ckd_en_o,
  output logic              clk_src_pll_o,
  output logic              lock_o
);
  logic       page_q;
  logic [6:0] store_q;
  ctl_bits_t  ctl_q;
  ctl_bits_t  ctl_nxt;

  logic addr_hit;
  logic wr_hit;
  logic wr_store;
  logic wr_ctl;
  logic pll_clr_blocked;
  logic sel_set_blocked;
  logic locked;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = addr_hit & bus_wr;
  assign wr_store = wr_hit & ~page_q;
  assign wr_ctl   = wr_hit & page_q;

  clkctl_interlock u_ilock (
    .wr_ctl          (wr_ctl),
    .want_vco        (bus_wdata[VCO_BIT]),
    .want_pll        (bus_wdata[PLLEN_BIT]),
    .want_sel        (bus_wdata[SEL_BIT]),
    .cur             (ctl_q),
    .opt_force       (opt_pll_src),
    .prog_force      (prog_session),
    .nxt             (ctl_nxt),
    .pll_clr_blocked (pll_clr_blocked),
    .sel_set_blocked (sel_set_blocked)
  );

  clkctl_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_en   (ctl_q.pll_en),
    .locked_o (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= 1'b0;
      store_q <= '0;
      ctl_q   <= '0;
    end else begin
      if (wr_hit)   page_q  <= bus_wdata[PAGE_BIT];
      if (wr_store) store_q <= bus_wdata[6:0];
      ctl_q <= ctl_nxt;
    end
  end

  always_comb begin
    if (!addr_hit)    bus_rdata = 8'h00;
    else if (page_q)  bus_rdata = pack_ctl_view(ctl_q, locked);
    else              bus_rdata = {1'b0, store_q};
  end

  assign vco_mode_o    = ctl_q.vco;
  assign pll_en_o      = ctl_q.pll_en;
  assign ckd_en_o      = ctl_q.pll_en;
  assign clk_src_pll_o = ctl_q.sel;
  assign lock_o        = locked;

  // R6: the PLL clock is never selected with the PLL off
  p_sel_implies_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.sel |-> ctl_q.pll_en);
  // R5: a refused clear leaves the PLL running
  p_clr_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_clr_blocked |=> ctl_q.pll_en);
  // R6: a refused select leaves the mux on the oscillator
  p_sel_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_set_blocked && !opt_pll_src && !prog_session) |=> !ctl_q.sel);
  // R7: option override wins over any write
  p_opt_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    opt_pll_src |=> (ctl_q.sel && ctl_q.pll_en));
  // R8: session force sets all three control bits
  p_prog_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_session |=> (ctl_q.vco && ctl_q.pll_en && ctl_q.sel));
  // R2: control-view writes leave the storage view alone
  p_store_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> $stable(store_q));
  // R3: reserved positions of the control view read 0
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && page_q) |-> ((bus_rdata & 8'h0D) == 8'h00));
  // R10: foreign addresses read 0
  p_miss_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == 8'h00));
endmodule

// File: tb/tb_pll_clkctl_reg.sv
`timescale 1ns/1ps
module tb_pll_clkctl_reg;
  localparam int        AW   = 4;
  localparam logic [3:0] RA  = 4'h9;
  localparam logic [3:0] OTHER = 4'h3;
  localparam int        LCYC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       opt_pll_src = 1'b0;
  logic       prog_session = 1'b0;
  logic       vco_mode_o, pll_en_o, ckd_en_o, clk_src_pll_o, lock_o;

  pll_clkctl_reg #(.ADDR_W(AW), .REG_ADDR(RA), .LOCK_CYCLES(LCYC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .opt_pll_src(opt_pll_src),
    .prog_session(prog_session), .vco_mode_o(vco_mode_o), .pll_en_o(pll_en_o),
    .ckd_en_o(ckd_en_o), .clk_src_pll_o(clk_src_pll_o), .lock_o(lock_o)
  );

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit       m_page;
  bit [6:0] m_store;
  bit       m_vco, m_pll, m_sel;
  int       m_run;

  function automatic bit m_lock();
    return m_pll && (m_run >= LCYC);
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == RA) begin
      if (m_page) begin
        v[7] = 1'b1; v[6] = m_vco; v[5] = m_lock(); v[4] = m_pll; v[1] = m_sel;
      end else begin
        v = {1'b0, m_store};
      end
    end
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "rdata", bus_rdata, m_read(bus_addr));
    chk("R4", "lock_o", {7'd0, lock_o}, {7'd0, m_lock()});
    chk("R9", "pll_en_o", {7'd0, pll_en_o}, {7'd0, m_pll});
    chk("R9", "ckd_en_o", {7'd0, ckd_en_o}, {7'd0, m_pll});
    chk("R9", "clk_src_pll_o", {7'd0, clk_src_pll_o}, {7'd0, m_sel});
    chk("R9", "vco_mode_o", {7'd0, vco_mode_o}, {7'd0, m_vco});
  endtask

  task automatic model_edge(input logic [3:0] a, input bit w, input logic [7:0] d,
                            input bit o, input bit p);
    bit nv, np, ns;
    nv = m_vco; np = m_pll; ns = m_sel;
    if (m_pll) m_run = (m_run < LCYC) ? m_run + 1 : LCYC;
    else       m_run = 0;
    if (w && a == RA) begin
      if (m_page) begin
        nv = d[6];
        if (d[4])        np = 1;
        else if (!m_sel) np = 0;
        if (!d[1])       ns = 0;
        else if (np)     ns = 1;
      end else begin
        m_store = d[6:0];
      end
      m_page = d[7];
    end
    if (o) begin np = 1; ns = 1; end
    if (p) begin nv = 1; np = 1; ns = 1; end
    m_vco = nv; m_pll = np; m_sel = ns;
  endtask

  task automatic step(input string tag, input logic [3:0] a, input bit w,
                      input logic [7:0] d, input bit o = 0, input bit p = 0);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; opt_pll_src = o; prog_session = p;
    #1 compare_all(tag);
    @(posedge clk);
    model_edge(a, w, d, o, p);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, RA, 0, 8'h00);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    m_page = 0; m_store = 0; m_vco = 0; m_pll = 0; m_sel = 0; m_run = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1", "reset rdata", bus_rdata, 8'h00);
    chk("R1", "reset outputs", {3'd0, vco_mode_o, pll_en_o, ckd_en_o, clk_src_pll_o, lock_o}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle("R1", 2);
    // storage view
    step("R2", RA, 1, 8'h5A);
    idle("R2", 1);
    step("R2", RA, 1, 8'h80);           // to control view; store gets 00
    idle("R3", 1);
    // lock is read-only
    step("R4", RA, 1, 8'hA0);
    // select without PLL refused
    step("R6", RA, 1, 8'h82);
    idle("R6", 1);
    // set both at once accepted
    step("R6", RA, 1, 8'hD2);
    idle("R4", LCYC + 2);
    // clear everything: PLL clear refused, select cleared
    step("R5", RA, 1, 8'h80);
    idle("R5", 2);
    // now PLL may drop, lock falls at once
    step("R4", RA, 1, 8'h80);
    idle("R4", 1);
    // restart PLL and break lock-in halfway
    step("R4", RA, 1, 8'h90);
    idle("R4", LCYC - 3);
    step("R4", RA, 1, 8'h80);
    step("R4", RA, 1, 8'h90);
    idle("R4", LCYC + 1);
    // foreign address
    step("R10", OTHER, 1, 8'h00);
    step("R10", OTHER, 0, 8'h00);
    idle("R10", 1);
    // option override
    step("R7", RA, 1, 8'h80, 1, 0);
    step("R7", RA, 1, 8'h80, 1, 0);
    step("R7", RA, 1, 8'h80, 1, 0);
    idle("R7", 1);
    step("R7", RA, 1, 8'h80);
    step("R7", RA, 1, 8'h80);
    idle("R7", 1);
    // session force, then release and unwind
    step("R8", RA, 1, 8'h80, 0, 1);
    step("R8", RA, 1, 8'h80, 0, 1);
    step("R8", RA, 0, 8'h00, 0, 1);
    step("R8", RA, 1, 8'hD0);
    idle("R8", 1);
    step("R8", RA, 1, 8'h80);
    idle("R8", 1);
    // back to storage view, store untouched by control writes
    step("R2", RA, 1, 8'h33);
    idle("R2", 1);
    // mixed pattern
    lfsr = 8'hA7;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[7] ? "R3" : "R2", (lfsr[2:0] == 3'd0) ? OTHER : RA,
           lfsr[0] | lfsr[3], {lfsr[4] ^ lfsr[1], lfsr[6:0]},
           (lfsr == 8'h11) || (lfsr == 8'h12), (lfsr[6:4] == 3'd5) && lfsr[0]);
    end
    idle("R4", 2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule